// File: doc/BRIEF.md
# Static Memory Data-Float Wait Controller

After a read, an external static device needs some cycles to release the data bus. This block sits inside the access sequencer of a static memory controller and works out how many idle cycles must pass before the next access may drive the bus. It keeps the float time still owed by the most recent read and sets it against each new request. A request gives a chip select and a direction. The block returns a wait-state count for that request and a ready signal that grants the access once the count has run out.

Each chip select has four programmable values: a float length, a read-hold length, a write-setup length and an optimization bit. The read-hold cycles always count as part of the float time. When the reading chip select has optimization on, the setup cycles of a following write are also taken off the float time still owed. The block does not generate the address, data or strobe waveforms, and it does not arbitrate the bus.

Top module: `float_gap_ctrl`

## Requirements
- R1: After reset no float time is owed, so any request is granted in the cycle it is presented and `wait_cnt` is 0.
- R2: Granting a read on chip select c loads an owed float time of max(0, F[c] − H[c]). F is the float field and H is the read-hold field of that chip select, each 4 bits wide at bits [4c+3:4c] of its bus. A float field of 0 means no float period.
- R3: The optimization bit of the reading chip select is bit c of `opt_en`. If it is 0, the next access waits for the whole owed time, whatever its direction.
- R4: If that bit is 1 and the next access is a write to chip select d, the wait is max(0, owed − S[d]). S[d] is the write-setup field at bits [4d+3:4d].
- R5: If that bit is 1 and the next access is a read on another chip select, no setup is subtracted, so the wait equals the owed time.
- R6: The owed time drops by one on every clock edge at which no access is granted, and stops at 0. A request presented g idle cycles after the read therefore sees g fewer cycles.
- R7: While a request is held unchanged and not granted, `wait_cnt` drops by one per cycle. `req_ready` rises in the cycle `wait_cnt` reaches 0, so the stall lasts exactly the first `wait_cnt` value.
- R8: A granted write clears any owed float time. The access after a write never waits.
- R9: A read that follows a read on the same chip select never waits.
- R10: `req_ready` is never high while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| float_cycles | input | NUM_CS*CNT_W | Float length per chip select, field c at [CNT_W*c +: CNT_W] |
| rd_hold | input | NUM_CS*CNT_W | Read-hold length per chip select |
| wr_setup | input | NUM_CS*CNT_W | Write-setup length per chip select |
| opt_en | input | NUM_CS | Float optimization enable per chip select |
| req_valid | input | 1 | An access is requested |
| req_cs | input | $clog2(NUM_CS) | Chip select of the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_ready | output | 1 | Grant: the access starts at this edge |
| wait_cnt | output | CNT_W | Wait states still owed by the presented request |

## Verification
The bench issues a read on chip select 0 with every float length, several hold and setup values and both optimization settings. It follows the read with four kinds of access: a read on another chip select, a write on another chip select, a write on the same chip select, and a read on the same chip select. Each kind is tried with and without idle gap cycles. The two chip selects get different setup values and opposite optimization bits, so a design that takes either value from the wrong chip select produces the wrong count. The gap cycles separate the idle countdown from the subtraction of hold and setup. Both the first `wait_cnt` and the number of stall cycles actually observed are compared, which catches a count that is right but is not honoured by the grant timing.

// File: rtl/float_gap_ctrl.sv
module float_gap_ctrl #(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CS*CNT_W-1:0] float_cycles,
  input  logic [NUM_CS*CNT_W-1:0] rd_hold,
  input  logic [NUM_CS*CNT_W-1:0] wr_setup,
  input  logic [NUM_CS-1:0]       opt_en,
  input  logic                    req_valid,
  input  logic [CS_W-1:0]         req_cs,
  input  logic                    req_write,
  output logic                    req_ready,
  output logic [CNT_W-1:0]        wait_cnt
);

  logic [CNT_W-1:0] left_q;
  logic [CS_W-1:0]  cs_q;
  logic             opt_q;

  logic [CNT_W-1:0] fc_sel, hold_sel, setup_sel, sub, load_val;
  logic             same_rd, grant;

  assign fc_sel    = float_cycles[req_cs*CNT_W +: CNT_W];
  assign hold_sel  = rd_hold[req_cs*CNT_W +: CNT_W];
  assign setup_sel = wr_setup[req_cs*CNT_W +: CNT_W];

  assign load_val = (fc_sel > hold_sel) ? fc_sel - hold_sel : '0;
  assign sub      = (opt_q && req_write) ? setup_sel : '0;
  assign same_rd  = !req_write && (req_cs == cs_q);
  assign wait_cnt = (same_rd || left_q <= sub) ? '0 : left_q - sub;
  assign grant    = req_valid && (wait_cnt == '0);
  assign req_ready = grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      cs_q   <= '0;
      opt_q  <= 1'b0;
    end else if (grant && !req_write) begin
      left_q <= load_val;
      cs_q   <= req_cs;
      opt_q  <= opt_en[req_cs];
    end else if (grant) begin
      left_q <= '0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

module float_gap_chk #(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [CS_W-1:0]  req_cs,
  input logic             req_write,
  input logic             req_ready,
  input logic [CNT_W-1:0] wait_cnt,
  input logic [CNT_W-1:0] left_q
);

  // R10
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  // R7
  stall_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && !$past(req_ready) && req_valid &&
     $stable(req_cs) && $stable(req_write)) |-> wait_cnt == $past(wait_cnt) - 1'b1);

  // R6
  owed_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_ready && !req_write) |-> left_q <= $past(left_q));

  // R8
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready && req_write) |-> left_q == '0);

  // R9
  same_cs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready && !req_write) && req_valid && !req_write &&
     req_cs == $past(req_cs)) |-> req_ready);

endmodule

bind float_gap_ctrl float_gap_chk #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_float_gap_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
  .req_write(req_write), .req_ready(req_ready), .wait_cnt(wait_cnt), .left_q(left_q)
);

// File: tb/float_gap_ctrl_bench.sv
module float_gap_ctrl_bench;
  localparam int NUM_CS = 4;
  localparam int CNT_W  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NUM_CS*CNT_W-1:0] float_cycles = '0, rd_hold = '0, wr_setup = '0;
  logic [NUM_CS-1:0] opt_en = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_cs = '0;
  logic req_ready;
  logic [CNT_W-1:0] wait_cnt;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  float_gap_ctrl u_float_gap_ctrl (
    .clk(clk), .rst_n(rst_n), .float_cycles(float_cycles), .rd_hold(rd_hold),
    .wr_setup(wr_setup), .opt_en(opt_en), .req_valid(req_valid), .req_cs(req_cs),
    .req_write(req_write), .req_ready(req_ready), .wait_cnt(wait_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v < 0) ? 0 : v;
  endfunction

  // present a request at a negedge, return first wait_cnt and stall cycles
  task automatic access(input int cs, input bit wr, output int first_w, output int stalls);
    req_valid = 1'b1; req_cs = 2'(cs); req_write = wr;
    #1;
    first_w = int'(wait_cnt);
    stalls = 0;
    while (!req_ready && stalls < 40) begin
      @(negedge clk); #1;
      stalls++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic trial(input int fc, input int h, input int s, input bit opt,
                       input int gap, input int kind);
    int w, st, owed, exp;
    string tag;
    float_cycles = '0; rd_hold = '0; wr_setup = '0;
    float_cycles[3:0] = 4'(fc); float_cycles[7:4] = 4'hF;
    rd_hold[3:0] = 4'(h);
    wr_setup[3:0] = 4'(s); wr_setup[7:4] = 4'(3 - s);
    opt_en = {2'b00, ~opt, opt};
    repeat (18) @(negedge clk);
    access(0, 1'b0, w, st);
    repeat (gap) @(negedge clk);
    owed = sat(sat(fc - h) - gap);
    case (kind)
      0: begin exp = owed; tag = opt ? "R5" : "R3"; access(1, 1'b0, w, st); end
      1: begin exp = opt ? sat(owed - (3 - s)) : owed; tag = opt ? "R4" : "R3"; access(1, 1'b1, w, st); end
      2: begin exp = opt ? sat(owed - s) : owed; tag = opt ? "R4" : "R2"; access(0, 1'b1, w, st); end
      default: begin exp = 0; tag = "R9"; access(0, 1'b0, w, st); end
    endcase
    if (gap != 0 && kind != 3) tag = "R6";
    check(tag, w, exp);
    check("R7", st, exp);
  endtask

  initial begin
    int w, st;
    repeat (3) @(negedge clk);
    // R1
    check("R1", int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    float_cycles = '1; rd_hold = '0;
    req_valid = 1'b0; #1;
    // R10
    check("R10", int'(req_ready), 0);
    access(2, 1'b0, w, st);
    check("R1", w, 0);
    check("R1", st, 0);
    // R8: write after read grant, then read on other cs sees nothing owed
    access(2, 1'b0, w, st);
    access(1, 1'b1, w, st);
    check("R8", st, 15);
    access(3, 1'b0, w, st);
    check("R8", w, 0);
    check("R8", st, 0);
    for (int fc = 0; fc < 16; fc++)
      for (int hi = 0; hi < 4; hi++)
        for (int s = 0; s < 4; s += 3)
          for (int opt = 0; opt < 2; opt++)
            for (int gap = 0; gap < 3; gap += 2)
              for (int kind = 0; kind < 4; kind++)
                trial(fc, (hi == 3) ? 7 : hi * 2, s, opt[0], gap, kind);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule